// File: doc/BRIEF.md
# Keyboard Scan-Code I2C Target

This block is an I2C target that sits between a keyboard byte source and a host controller. Scan-code bytes arrive on a simple push interface and are kept in a small FIFO. The host reaches them through a one-byte register pointer. It first writes the pointer index after the write address. Then, after a repeated START or a fresh START, it addresses the target for reading and clocks out the data byte, ending with a NAK. The scan-code register pops one byte per read. A code sequence of several bytes is therefore collected with one read transaction per byte, or with a single read that the host keeps acknowledging.

Both bus lines are open-drain. The block sees the line levels and returns one pull-low enable per line. Before it decodes any edge, each line passes through a two-flop synchronizer and a stability filter. Whenever a byte has to be fetched for transmission, the target holds SCL low for a fixed preparation time. The first data bit is therefore on SDA before the host can raise the clock, and a slow fetch path cannot miss the response window.

Top module: `kbd_i2c_target`

## Requirements
- R1: The target acknowledges only an address byte whose upper seven bits equal the TARGET_ADDR parameter (default 0x42). A foreign address gets no ACK, and the target stays silent until the next START.
- R2: The byte written after the write address becomes the register pointer. The pointer is kept across later transactions, and transactions to other addresses leave it unchanged.
- R3: Reading index 7 returns the oldest buffered scan-code byte and removes it, so that bytes come out in push order.
- R4: Reading index 7 while the FIFO is empty returns 0x00.
- R5: Index 0 returns the ID_BYTE parameter (default 0xA5). Every index other than 0, 1 and 7 returns 0x00.
- R6: Index 1 is a status byte. Bit 7 is a sticky overflow flag and bits 6:0 hold the FIFO fill count. Reading index 1 clears the flag.
- R7: The FIFO holds DEPTH bytes (default 16). A push while it is full is dropped, leaves the stored bytes intact and sets the overflow flag.
- R8: After the read-address ACK, and after every host ACK of a data byte, the target holds SCL low for PREP_CYCLES clock cycles while it loads the next byte.
- R9: The target changes its SDA drive only while SCL is low.
- R10: A host ACK after a data byte makes the target supply the next byte at the same pointer. A host NAK makes it release SDA and wait for a START.
- R11: A pulse on SCL or SDA shorter than FILT_LEN clock cycles has no effect on bus decoding.
- R12: While in reset and right after it, the target drives neither line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sensed SCL line level |
| sdaIn | input | 1 | Sensed SDA line level |
| sclDriveLow | output | 1 | Pull SCL low when 1 (clock stretch) |
| sdaDriveLow | output | 1 | Pull SDA low when 1 (ACK or data 0) |
| codeValid | input | 1 | One-cycle strobe that pushes codeByte |
| codeByte | input | 8 | Scan-code byte from the keyboard side |

## Verification
If the FIFO pointers or the fill count go wrong, the next read of index 7 or index 1 shows a wrong byte or a wrong count, already at the first data byte after the failure. If the bit counter or the state sequence slips, the ACK bit lands on the wrong clock, or the data comes out shifted by one position, within the same transaction. If the stretch or the SDA timing goes wrong, the host sees no SCL hold at the start of a read byte, or sees SDA move while SCL is high, both within a single bit time.

// File: rtl/kbd_i2c_pkg.sv
package kbd_i2c_pkg;

  // Strobes from the bus sequencer to the datapath
  typedef struct packed {
    logic shiftRx;   // sample one SDA bit into the receive byte
    logic storePtr;  // receive byte becomes the register pointer
    logic loadTx;    // fetch the addressed register into the transmit byte
    logic shiftTx;   // advance the transmit byte by one bit
  } ctrlStrobe_t;

  // Filtered bus events from the datapath to the sequencer
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaNow;
    logic sclNow;
  } busEvent_t;

  localparam logic [7:0] REG_ID     = 8'd0;
  localparam logic [7:0] REG_STATUS = 8'd1;
  localparam logic [7:0] REG_SCAN   = 8'd7;

endpackage

// File: rtl/kbd_i2c_data.sv
module kbd_i2c_data
  import kbd_i2c_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FILT_LEN = 3,
  parameter logic [7:0] ID_BYTE = 8'hA5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        codeValid,
  input  logic [7:0]  codeByte,
  input  ctrlStrobe_t stb,
  output busEvent_t   ev,
  output logic [7:0]  rxByte,
  output logic        txBit
);
  localparam int AW = $clog2(DEPTH);
  localparam int CNTW = AW + 1;
  localparam int FW = $clog2(FILT_LEN + 1);

  // ---------------- line conditioning ----------------
  logic [1:0] rawLine;
  logic [1:0] lineF;
  assign rawLine = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : gLine
    logic [1:0]    syncQ;
    logic [FW-1:0] stableCnt;
    logic          filtQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncQ     <= 2'b11;
        stableCnt <= '0;
        filtQ     <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawLine[g]};
        if (syncQ[1] == filtQ) begin
          stableCnt <= '0;
        end else if (stableCnt == FW'(FILT_LEN - 1)) begin
          filtQ     <= syncQ[1];
          stableCnt <= '0;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end
    end
    assign lineF[g] = filtQ;
  end

  logic sclPrev, sdaPrev;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= lineF[1];
      sdaPrev <= lineF[0];
    end
  end

  always_comb begin
    ev.sclNow    = lineF[1];
    ev.sdaNow    = lineF[0];
    ev.sclRise   = lineF[1] & ~sclPrev;
    ev.sclFall   = ~lineF[1] & sclPrev;
    ev.startSeen = lineF[1] & sclPrev & sdaPrev & ~lineF[0];
    ev.stopSeen  = lineF[1] & sclPrev & ~sdaPrev & lineF[0];
  end

  // ---------------- scan-code FIFO ----------------
  logic [7:0]      fifoMem [DEPTH];
  logic [AW-1:0]   wrPtr, rdPtr;
  logic [CNTW-1:0] fillCnt;
  logic            ovfFlag;
  logic [7:0]      regPtr;
  logic            isFull, isEmpty, doPush, doPop, clrOvf;

  assign isFull  = (fillCnt == CNTW'(DEPTH));
  assign isEmpty = (fillCnt == '0);
  assign doPush  = codeValid & ~isFull;
  assign doPop   = stb.loadTx & (regPtr == REG_SCAN) & ~isEmpty;
  assign clrOvf  = stb.loadTx & (regPtr == REG_STATUS);

  always_ff @(posedge clk) begin
    if (doPush) fifoMem[wrPtr] <= codeByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
      if (codeValid && isFull) ovfFlag <= 1'b1;
      else if (clrOvf)         ovfFlag <= 1'b0;
    end
  end

  // ---------------- shift registers and pointer ----------------
  logic [7:0] txShift, readMux;

  always_comb begin
    case (regPtr)
      REG_ID:     readMux = ID_BYTE;
      REG_STATUS: readMux = {ovfFlag, 7'(fillCnt)};
      REG_SCAN:   readMux = isEmpty ? 8'h00 : fifoMem[rdPtr];
      default:    readMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte  <= '0;
      txShift <= '0;
      regPtr  <= '0;
    end else begin
      if (stb.shiftRx)  rxByte <= {rxByte[6:0], lineF[0]};
      if (stb.storePtr) regPtr <= rxByte;
      if (stb.loadTx)       txShift <= readMux;
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  assign txBit = txShift[7];

  // R7: a push into a full FIFO is dropped and flags overflow
  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && isFull && !doPop) |=> (fillCnt == CNTW'(DEPTH)) && ovfFlag);
  // R4: popping an empty FIFO leaves it empty
  a_r4_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadTx && regPtr == REG_SCAN && isEmpty && !codeValid) |=> (fillCnt == '0));
  // R11: the filtered SCL level moves only after the synchronized input changes
  a_r11_filter_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lineF[1]) |-> $past(gLine[1].syncQ[1]) == lineF[1]);

endmodule

// File: rtl/kbd_i2c_ctrl.sv
module kbd_i2c_ctrl
  import kbd_i2c_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h42,
  parameter int PREP_CYCLES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  busEvent_t   ev,
  input  logic [7:0]  rxByte,
  input  logic        txBit,
  output ctrlStrobe_t stb,
  output logic        sdaDriveLow,
  output logic        sclDriveLow
);
  localparam int PCW = $clog2(PREP_CYCLES + 1);

  typedef enum logic [2:0] {S_WAIT, S_RX, S_ACK, S_PREP, S_TX, S_TXACK} busState_t;

  busState_t      state;
  logic [3:0]     bitCnt;
  logic [PCW-1:0] prepCnt;
  logic           isAddr, rdMode, ackSeen, addrHit;

  assign addrHit = (rxByte[7:1] == TARGET_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_WAIT;
      bitCnt  <= '0;
      prepCnt <= '0;
      isAddr  <= 1'b0;
      rdMode  <= 1'b0;
      ackSeen <= 1'b0;
    end else if (ev.stopSeen) begin
      state <= S_WAIT;
    end else if (ev.startSeen) begin
      state  <= S_RX;
      isAddr <= 1'b1;
      bitCnt <= '0;
    end else begin
      case (state)
        S_RX: begin
          if (ev.sclRise) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (ev.sclFall && bitCnt == 4'd8) begin
            if (!isAddr) begin
              state <= S_ACK;
            end else if (addrHit) begin
              state  <= S_ACK;
              rdMode <= rxByte[0];
            end else begin
              state <= S_WAIT;
            end
          end
        end
        S_ACK: begin
          if (ev.sclFall) begin
            bitCnt <= '0;
            if (!isAddr) begin
              state <= S_WAIT;
            end else if (rdMode) begin
              state   <= S_PREP;
              prepCnt <= '0;
            end else begin
              state  <= S_RX;
              isAddr <= 1'b0;
            end
          end
        end
        S_PREP: begin
          if (prepCnt == PCW'(PREP_CYCLES - 1)) begin
            state  <= S_TX;
            bitCnt <= '0;
          end else begin
            prepCnt <= prepCnt + 1'b1;
          end
        end
        S_TX: begin
          if (ev.sclFall) begin
            if (bitCnt == 4'd7) state <= S_TXACK;
            bitCnt <= bitCnt + 1'b1;
          end
        end
        S_TXACK: begin
          if (ev.sclRise) begin
            ackSeen <= ~ev.sdaNow;
          end else if (ev.sclFall) begin
            if (ackSeen) begin
              state   <= S_PREP;
              prepCnt <= '0;
            end else begin
              state <= S_WAIT;
            end
          end
        end
        default: state <= S_WAIT;
      endcase
    end
  end

  always_comb begin
    stb.shiftRx  = (state == S_RX) & ev.sclRise;
    stb.storePtr = (state == S_RX) & ~isAddr & ev.sclFall & (bitCnt == 4'd8);
    stb.loadTx   = (state == S_PREP) & (prepCnt == '0);
    stb.shiftTx  = (state == S_TX) & ev.sclFall;
  end

  assign sclDriveLow = (state == S_PREP);
  assign sdaDriveLow = (state == S_ACK)
                     | ((state == S_TX) & ~txBit)
                     | ((state == S_PREP) & (prepCnt != '0) & ~txBit);

  // R9: the SDA drive moves only while filtered SCL is low
  a_r9_sda_while_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !ev.sclNow);
  // R8: a stretch begins only once the host has pulled SCL low
  a_r8_stretch_on_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> !ev.sclNow);
  // R1: an address ACK only follows a matching address byte
  a_r1_ack_own_addr: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACK && isAddr) |-> addrHit);
  // R10: a host NAK returns the target to waiting with SDA released
  a_r10_nak_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TXACK && ev.sclFall && !ackSeen && !ev.startSeen && !ev.stopSeen)
      |=> (state == S_WAIT) && !sdaDriveLow);

endmodule

// File: rtl/kbd_i2c_target.sv
module kbd_i2c_target
  import kbd_i2c_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h42,
  parameter int DEPTH = 16,
  parameter int FILT_LEN = 3,
  parameter int PREP_CYCLES = 32,
  parameter logic [7:0] ID_BYTE = 8'hA5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclDriveLow,
  output logic       sdaDriveLow,
  input  logic       codeValid,
  input  logic [7:0] codeByte
);
  ctrlStrobe_t stb;
  busEvent_t   ev;
  logic [7:0]  rxByte;
  logic        txBit;

  kbd_i2c_data #(
    .DEPTH(DEPTH), .FILT_LEN(FILT_LEN), .ID_BYTE(ID_BYTE)
  ) i_data (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .codeValid(codeValid), .codeByte(codeByte),
    .stb(stb), .ev(ev), .rxByte(rxByte), .txBit(txBit)
  );

  kbd_i2c_ctrl #(
    .TARGET_ADDR(TARGET_ADDR), .PREP_CYCLES(PREP_CYCLES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .txBit(txBit),
    .stb(stb), .sdaDriveLow(sdaDriveLow), .sclDriveLow(sclDriveLow)
  );

  // R12: nothing is pulled low in the cycle after reset
  a_r12_idle_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> !sclDriveLow && !sdaDriveLow);

endmodule

// File: tb/test_kbd_i2c_target.sv
module test_kbd_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam int DEPTH = 16;
  localparam logic [6:0] ADDR = 7'h42;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mSclLow = 1'b0, mSdaLow = 1'b0;
  logic codeValid = 1'b0;
  logic [7:0] codeByte = 8'h00;
  logic sclDriveLow, sdaDriveLow;
  logic sclLine, sdaLine;

  assign sclLine = !(mSclLow || sclDriveLow);
  assign sdaLine = !(mSdaLow || sdaDriveLow);

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_i2c_target i_kbd_i2c_target (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .codeValid(codeValid), .codeByte(codeByte)
  );

  int checks = 0, errors = 0, sdaViol = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  bit ovfModel = 1'b0;
  logic [7:0] modelPtr = 8'h00;
  logic prevSdaDrv = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // R9 monitor: target SDA drive must not move while SCL is high
  always @(negedge clk) begin
    if (rstN && (sdaDriveLow != prevSdaDrv) && sclLine) sdaViol++;
    prevSdaDrv <= sdaDriveLow;
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic releaseScl(output int waited, input bit glitch);
    mSclLow = 1'b0;
    waited = 0;
    while (!sclLine) begin
      @(negedge clk);
      waited++;
    end
    if (glitch) begin
      @(negedge clk);
      mSclLow = 1'b1;
      @(negedge clk);
      mSclLow = 1'b0;
    end
  endtask

  task automatic busStart();
    int w;
    mSdaLow = 1'b0; waitQ();
    releaseScl(w, 1'b0); waitQ();
    mSdaLow = 1'b1; waitQ();
    mSclLow = 1'b1; waitQ();
  endtask

  task automatic busStop();
    int w;
    mSdaLow = 1'b1; waitQ();
    releaseScl(w, 1'b0); waitQ();
    mSdaLow = 1'b0; waitQ();
  endtask

  task automatic writeBit(input bit b, input bit glitch, output bit sampled);
    int w;
    mSdaLow = !b; waitQ();
    releaseScl(w, glitch); waitQ();
    sampled = sdaLine;
    mSclLow = 1'b1; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, input bit glitch, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) writeBit(b[i], glitch, s);
    writeBit(1'b1, 1'b0, s);
    acked = !s;
  endtask

  task automatic readByte(input bit hostAck, output logic [7:0] val, output int stretch);
    int w;
    bit s;
    for (int i = 7; i >= 0; i--) begin
      mSdaLow = 1'b0; waitQ();
      releaseScl(w, 1'b0);
      if (i == 7) stretch = w;
      waitQ();
      val[i] = sdaLine;
      mSclLow = 1'b1; waitQ();
    end
    writeBit(!hostAck, 1'b0, s);
  endtask

  // scoreboard: driver side
  task automatic pushCode(input logic [7:0] b);
    @(negedge clk);
    codeValid = 1'b1;
    codeByte = b;
    if (expQ.size() < DEPTH) expQ.push_back(b);
    else ovfModel = 1'b1;
    @(negedge clk);
    codeValid = 1'b0;
  endtask

  task automatic modelRead(output logic [7:0] e);
    case (modelPtr)
      8'd7: e = (expQ.size() > 0) ? expQ.pop_front() : 8'h00;
      8'd1: begin e = {ovfModel, 7'(expQ.size())}; ovfModel = 1'b0; end
      8'd0: e = 8'hA5;
      default: e = 8'h00;
    endcase
  endtask

  // scoreboard: monitor side, compares each byte as it is clocked out
  task automatic readReg(input logic [7:0] ptr, input bit setPtr, input int n,
                         input bit glitch, input string tag);
    bit a;
    logic [7:0] v, e;
    int st;
    busStart();
    if (setPtr) begin
      writeByte({ADDR, 1'b0}, glitch, a);
      check(a, glitch ? "R11" : "R1", a, 1);
      writeByte(ptr, 1'b0, a);
      check(a, "R2", a, 1);
      modelPtr = ptr;
      busStart();
    end
    writeByte({ADDR, 1'b1}, 1'b0, a);
    check(a, "R1", a, 1);
    for (int k = 0; k < n; k++) begin
      readByte(k != n - 1, v, st);
      modelRead(e);
      check(v == e, tag, v, e);
      check(st > 0, "R8", st, 1);
    end
    busStop();
  endtask

  initial begin
    bit a;
    repeat (3) @(negedge clk);
    check(!sclDriveLow && !sdaDriveLow, "R12", {sclDriveLow, sdaDriveLow}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(!sclDriveLow && !sdaDriveLow, "R12", {sclDriveLow, sdaDriveLow}, 0);

    readReg(8'd0, 1'b1, 1, 1'b0, "R5");
    readReg(8'd7, 1'b1, 1, 1'b0, "R4");

    pushCode(8'hE0); pushCode(8'h1C); pushCode(8'hF0);
    readReg(8'd7, 1'b1, 1, 1'b0, "R3");
    readReg(8'd7, 1'b0, 1, 1'b0, "R3");
    readReg(8'd7, 1'b0, 1, 1'b0, "R3");

    readReg(8'd5, 1'b1, 1, 1'b0, "R5");
    readReg(8'd0, 1'b1, 1, 1'b0, "R2");

    // foreign address: no ACK, no effect on the pointer
    busStart();
    writeByte({7'h13, 1'b0}, 1'b0, a);
    check(!a, "R1", a, 0);
    writeByte(8'h07, 1'b0, a);
    check(!a, "R1", a, 0);
    busStop();
    readReg(8'd0, 1'b0, 1, 1'b0, "R2");

    for (int i = 0; i < DEPTH + 2; i++) pushCode(8'(i * 7 + 3));
    readReg(8'd1, 1'b1, 1, 1'b0, "R7");
    readReg(8'd1, 1'b0, 1, 1'b0, "R6");

    readReg(8'd7, 1'b1, DEPTH, 1'b0, "R10");
    check(!sdaDriveLow, "R10", sdaDriveLow, 0);
    readReg(8'd7, 1'b0, 1, 1'b0, "R4");

    readReg(8'd0, 1'b1, 1, 1'b1, "R11");

    check(sdaViol == 0, "R9", sdaViol, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule